// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Requests

This block sits between a simple register bus and a serial audio engine. It holds one queue of outgoing samples, filled by bus writes and drained by the engine, and one queue of incoming samples, filled by the engine and drained by bus reads. Each queue is 32 entries deep and reports its fill level in a shared FIFO status word.

Each queue has a 5-bit threshold. When the transmit queue has enough free room, a transmit-room flag is raised. When the receive queue holds more than its threshold, a receive-ready flag is raised. Each flag can drive a request output that feeds an interrupt controller or a DMA engine. Writing 0 to a flag clears it. Writing 1 to a flag leaves it unchanged.

Four sticky error flags record underflow and overflow on either queue. Each error flag has its own interrupt enable. While any error flag is set, the engine side of both queues is frozen, so software has to clear the errors and reset the queues before traffic resumes. Per-queue reset bits hold a queue empty. A soft reset bit empties both queues and clears every flag.

Top module: `audio_fifo_pair`

## Requirements
- R1: While reset is applied, tx_req, rx_req and err_irq are 0, the FIFO status word reads 0 and the interface status word reads 0x0200_0000. Bit 25 of the interface status word is the idle bit, which reads 1 while both queues are empty.
- R2: Both queues are first-in first-out and hold 32 samples. The transmit fill count reads at bits 29:24 and the receive fill count reads at bits 13:8 of the FIFO status word (address 1). The transmit data port is address 4 and the receive data port is address 5.
- R3: A bus write to the transmit port while the transmit queue is full is dropped and sets transmit overflow (interface status bit 28, address 3).
- R4: A bus read of the receive port while the receive queue is empty returns 0 and sets receive underflow (bit 27).
- R5: An engine pop from an empty transmit queue yields a word of 0 and sets transmit underflow (bit 29).
- R6: An engine push into a full receive queue is dropped and sets receive overflow (bit 26).
- R7: The transmit-room flag (FIFO status bit 16) is set when the free space is at least the transmit threshold plus 1. The transmit threshold sits at bits 12:8 of the threshold register (address 2).
- R8: The receive-ready flag (FIFO status bit 0) is set when the receive fill count exceeds the receive threshold, which sits at bits 4:0 of the threshold register.
- R9: A flag is cleared by writing 0 to its bit and is unchanged by writing 1. A request flag whose condition still holds is set again on the next cycle. Error flags stay set until they are cleared.
- R10: Control register (address 0) bit 1 holds the transmit queue empty and bit 0 holds the receive queue empty. While a queue is held, accesses to it are ignored and raise no error.
- R11: tx_req is the transmit-room flag gated by control bit 3. rx_req is the receive-ready flag gated by control bit 2.
- R12: Control bit 16 is a soft reset. While it is set, both queues are empty and all request and error flags are 0.
- R13: While any error flag is set, engine pops and pushes are ignored. Bus-side accesses still act.
- R14: err_irq is 1 when any error flag is set together with its enable. The enables are control bits 7, 6, 5 and 4, for transmit underflow, transmit overflow, receive underflow and receive overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive port) |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tx_pop | input | 1 | Engine takes the transmit head word |
| tx_word | output | SW | Transmit head word, 0 when empty |
| rx_push | input | 1 | Engine delivers a received word |
| rx_word | input | SW | Received word |
| tx_req | output | 1 | Transmit-room request |
| rx_req | output | 1 | Receive-ready request |
| err_irq | output | 1 | Enabled error interrupt |

## Verification
The hardest state to reach is a full queue with an error pending. In that state the engine-side freeze has to be separated from normal draining. The bench fills the transmit queue through the bus port one word at a time, overflows it, and then pops from the engine side while the error is pending to show that the count does not move. It then clears the error and drains all 32 words in order. Each threshold test stops exactly one entry short of its boundary, clears the flag, checks that it stays low, and then moves one entry across the boundary.

// File: rtl/audio_fifo_pair.sv
module audio_fifo_pair #(
  parameter int DEPTH = 32,
  parameter int SW    = 16,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          tx_pop,
  output logic [SW-1:0] tx_word,
  input  logic          rx_push,
  input  logic [SW-1:0] rx_word,
  output logic          tx_req,
  output logic          rx_req,
  output logic          err_irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = 5;
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_FSTAT = AW'(1), A_THR = AW'(2),
                            A_ISTAT = AW'(3), A_TXD = AW'(4), A_RXD = AW'(5);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic c_txrst, c_rxrst, c_tie, c_rie, c_srst;
  logic [3:0] c_en;
  logic [TW-1:0] thr_tx, thr_rx;
  logic tde, rdf;
  logic [3:0] err;

  logic [SW-1:0] tmem [DEPTH];
  logic [SW-1:0] rmem [DEPTH];
  logic [PW-1:0] twp, trp, rwp, rrp;
  logic [CW-1:0] tcnt, rcnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  logic wr_ctrl, wr_fstat, wr_thr, wr_istat;
  assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  assign wr_fstat = bus_wr && bus_addr == A_FSTAT;
  assign wr_thr   = bus_wr && bus_addr == A_THR;
  assign wr_istat = bus_wr && bus_addr == A_ISTAT;

  logic tx_hold, rx_hold, any_err, t_empty, t_full, r_empty, r_full;
  assign tx_hold = c_txrst || c_srst;
  assign rx_hold = c_rxrst || c_srst;
  assign any_err = |err;
  assign t_empty = tcnt == '0;
  assign t_full  = tcnt == FULL;
  assign r_empty = rcnt == '0;
  assign r_full  = rcnt == FULL;

  logic bus_txw, eng_pop, t_push, t_pop, t_ovf, t_unf;
  assign bus_txw = bus_wr && bus_addr == A_TXD && !tx_hold;
  assign eng_pop = tx_pop && !tx_hold && !any_err;
  assign t_push  = bus_txw && !t_full;
  assign t_ovf   = bus_txw && t_full;
  assign t_pop   = eng_pop && !t_empty;
  assign t_unf   = eng_pop && t_empty;

  logic bus_rxr, eng_push, r_push, r_pop, r_ovf, r_unf;
  assign bus_rxr  = bus_rd && bus_addr == A_RXD && !rx_hold;
  assign eng_push = rx_push && !rx_hold && !any_err;
  assign r_push   = eng_push && !r_full;
  assign r_ovf    = eng_push && r_full;
  assign r_pop    = bus_rxr && !r_empty;
  assign r_unf    = bus_rxr && r_empty;

  logic [CW:0] t_free;
  logic tde_cond, rdf_cond;
  assign t_free   = {1'b0, FULL} - {1'b0, tcnt};
  assign tde_cond = t_free >= ((CW+1)'(thr_tx) + (CW+1)'(1));
  assign rdf_cond = rcnt > CW'(thr_rx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_rxrst <= 1'b0; c_txrst <= 1'b0; c_rie <= 1'b0; c_tie <= 1'b0;
      c_en <= '0; c_srst <= 1'b0; thr_rx <= '0; thr_tx <= '0;
    end else begin
      if (wr_ctrl) begin
        c_rxrst <= bus_wdata[0];
        c_txrst <= bus_wdata[1];
        c_rie   <= bus_wdata[2];
        c_tie   <= bus_wdata[3];
        c_en    <= bus_wdata[7:4];
        c_srst  <= bus_wdata[16];
      end
      if (wr_thr) begin
        thr_rx <= bus_wdata[4:0];
        thr_tx <= bus_wdata[12:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0;
    end else if (tx_hold) begin
      twp <= '0; trp <= '0; tcnt <= '0;
    end else begin
      if (t_push) twp <= nxt(twp);
      if (t_pop)  trp <= nxt(trp);
      tcnt <= tcnt + CW'(t_push) - CW'(t_pop);
    end
  end

  always_ff @(posedge clk) if (t_push) tmem[twp] <= bus_wdata[SW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else if (rx_hold) begin
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (r_push) rwp <= nxt(rwp);
      if (r_pop)  rrp <= nxt(rrp);
      rcnt <= rcnt + CW'(r_push) - CW'(r_pop);
    end
  end

  always_ff @(posedge clk) if (r_push) rmem[rwp] <= rx_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tde <= 1'b0; rdf <= 1'b0; err <= '0;
    end else if (c_srst) begin
      tde <= 1'b0; rdf <= 1'b0; err <= '0;
    end else begin
      if (wr_fstat && !bus_wdata[16]) tde <= 1'b0;
      else if (tde_cond)              tde <= 1'b1;
      if (wr_fstat && !bus_wdata[0])  rdf <= 1'b0;
      else if (rdf_cond)              rdf <= 1'b1;
      err[3] <= (err[3] && !(wr_istat && !bus_wdata[29])) || t_unf;
      err[2] <= (err[2] && !(wr_istat && !bus_wdata[28])) || t_ovf;
      err[1] <= (err[1] && !(wr_istat && !bus_wdata[27])) || r_unf;
      err[0] <= (err[0] && !(wr_istat && !bus_wdata[26])) || r_ovf;
    end
  end

  logic idle;
  assign idle = t_empty && r_empty;

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {15'b0, c_srst, 8'b0, c_en, c_tie, c_rie, c_txrst, c_rxrst};
      A_FSTAT: bus_rdata = {2'b0, 6'(tcnt), 7'b0, tde, 2'b0, 6'(rcnt), 7'b0, rdf};
      A_THR:   bus_rdata = {19'b0, thr_tx, 3'b0, thr_rx};
      A_ISTAT: bus_rdata = {2'b0, err, idle, 25'b0};
      A_RXD:   bus_rdata = (r_empty || rx_hold) ? 32'b0 : {(32-SW)'(0), rmem[rrp]};
      default: bus_rdata = 32'b0;
    endcase
  end

  assign tx_word = (t_empty || tx_hold) ? '0 : tmem[trp];
  assign tx_req  = tde && c_tie;
  assign rx_req  = rdf && c_rie;
  assign err_irq = |(err & c_en);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/audio_fifo_pair_chk.sv
module audio_fifo_pair_chk #(
  parameter int DEPTH = 32,
  parameter int AW    = 3,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_rdata,
  input logic [CW-1:0] tcnt,
  input logic [CW-1:0] rcnt,
  input logic [3:0]    err,
  input logic          tde,
  input logic          rdf,
  input logic          c_txrst,
  input logic          c_srst
);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= CW'(DEPTH) && rcnt <= CW'(DEPTH));

  assert_tx_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(4) && tcnt == CW'(DEPTH) && !c_txrst && !c_srst) |=> err[2]);

  assert_rx_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(5) && rcnt == '0) |-> bus_rdata == 32'b0);

  assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err[0] && !(bus_wr && bus_addr == AW'(3)) && !c_srst) |=> err[0]);

  assert_tx_hold_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    c_txrst |=> tcnt == '0);

  assert_soft_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    c_srst |=> (err == '0 && !tde && !rdf && tcnt == '0 && rcnt == '0));

  assert_engine_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (|err && !bus_wr && !c_txrst && !c_srst) |=> $stable(tcnt));
endmodule

bind audio_fifo_pair audio_fifo_pair_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .tcnt(tcnt), .rcnt(rcnt), .err(err), .tde(tde), .rdf(rdf),
  .c_txrst(c_txrst), .c_srst(c_srst)
);

// File: tb/tb_audio_fifo_pair.sv
module tb_audio_fifo_pair;
  localparam int CLK_P = 10;
  localparam int DEPTH = 32;
  localparam int SW = 16;
  localparam logic [2:0] A_CTRL = 3'd0, A_FSTAT = 3'd1, A_THR = 3'd2,
                         A_ISTAT = 3'd3, A_TXD = 3'd4, A_RXD = 3'd5;

  logic clk, rst_n, bus_wr, bus_rd, tx_pop, rx_push;
  logic [2:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [SW-1:0] tx_word, rx_word;
  logic tx_req, rx_req, err_irq;

  audio_fifo_pair #(.DEPTH(DEPTH), .SW(SW), .AW(3)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_pop(tx_pop), .tx_word(tx_word),
    .rx_push(rx_push), .rx_word(rx_word), .tx_req(tx_req), .rx_req(rx_req),
    .err_irq(err_irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] echo;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    #1 echo = bus_rdata;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic epop(output logic [SW-1:0] w);
    @(negedge clk);
    tx_pop = 1'b1;
    #1 w = tx_word;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic epush(input logic [SW-1:0] v);
    @(negedge clk);
    rx_push = 1'b1; rx_word = v;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic clean();
    wr(A_CTRL, 32'h3);
    wr(A_CTRL, 32'h0);
    wr(A_ISTAT, 32'h0);
    wr(A_THR, 32'h0);
    wr(A_FSTAT, 32'h0);
  endtask

  task automatic t_reset();
    bus_addr = A_FSTAT;
    #1 chk("R1 fstat", bus_rdata, 32'h0);
    chk("R1 reqs", {29'b0, tx_req, rx_req, err_irq}, 32'h0);
    bus_addr = A_ISTAT;
    #1 chk("R1 istat", bus_rdata, 32'h0200_0000);
  endtask

  task automatic t_order();
    logic [31:0] s;
    logic [SW-1:0] w;
    clean();
    wr(A_TXD, 32'h11); wr(A_TXD, 32'h22); wr(A_TXD, 32'h33);
    rd(A_FSTAT, s); chk("R2 tx count", 32'(s[29:24]), 32'd3);
    epop(w); chk("R2 tx order", 32'(w), 32'h11);
    epop(w); chk("R2 tx order", 32'(w), 32'h22);
    epop(w); chk("R2 tx order", 32'(w), 32'h33);
    epush(16'hAA); epush(16'hBB);
    rd(A_FSTAT, s); chk("R2 rx count", 32'(s[13:8]), 32'd2);
    rd(A_RXD, s); chk("R2 rx order", s, 32'hAA);
    rd(A_RXD, s); chk("R2 rx order", s, 32'hBB);
    rd(A_FSTAT, s); chk("R2 counts empty", {s[29:24], s[13:8]}, 32'h0);
  endtask

  task automatic t_full_overflow();
    logic [31:0] s;
    logic [SW-1:0] w;
    clean();
    for (int i = 1; i <= DEPTH; i++) wr(A_TXD, 32'(i));
    rd(A_FSTAT, s); chk("R2 full count", 32'(s[29:24]), 32'd32);
    wr(A_TXD, 32'hDEAD);
    rd(A_ISTAT, s); chk("R3 overflow flag", 32'(s[28]), 32'd1);
    epop(w);
    rd(A_FSTAT, s); chk("R13 pop frozen", 32'(s[29:24]), 32'd32);
    chk("R14 irq masked", 32'(err_irq), 32'd0);
    wr(A_ISTAT, 32'h0);
    for (int i = 1; i <= DEPTH; i++) begin
      epop(w); chk("R2/R3 drain order", 32'(w), 32'(i));
    end
    rd(A_FSTAT, s); chk("R3 no extra word", 32'(s[29:24]), 32'd0);
  endtask

  task automatic t_tx_underflow();
    logic [31:0] s;
    logic [SW-1:0] w;
    clean();
    epop(w); chk("R5 empty word", 32'(w), 32'd0);
    rd(A_ISTAT, s); chk("R5 flags", 32'(s[29:26]), 32'b1000);
  endtask

  task automatic t_rx_underflow();
    logic [31:0] s;
    clean();
    rd(A_RXD, s); chk("R4 empty read", s, 32'd0);
    rd(A_ISTAT, s); chk("R4 flags", 32'(s[29:26]), 32'b0010);
  endtask

  task automatic t_rx_overflow();
    logic [31:0] s;
    clean();
    for (int i = 1; i <= DEPTH + 1; i++) epush(SW'(32'h100 + i));
    rd(A_ISTAT, s); chk("R6 flags", 32'(s[29:26]), 32'b0001);
    wr(A_ISTAT, 32'h0);
    rd(A_FSTAT, s); chk("R6 count", 32'(s[13:8]), 32'd32);
    for (int i = 1; i <= DEPTH; i++) begin
      rd(A_RXD, s);
      if (i == 1 || i == DEPTH) chk("R6 kept words", s, 32'h100 + 32'(i));
    end
    rd(A_FSTAT, s); chk("R6 dropped word", 32'(s[13:8]), 32'd0);
  endtask

  task automatic t_tx_threshold();
    logic [31:0] s;
    logic [SW-1:0] w;
    clean();
    wr(A_THR, 32'h0000_0400);
    for (int i = 0; i < 28; i++) wr(A_TXD, 32'(i));
    wr(A_FSTAT, 32'h0);
    idle(1);
    rd(A_FSTAT, s); chk("R7 free 4 below", 32'(s[16]), 32'd0);
    epop(w);
    idle(1);
    rd(A_FSTAT, s); chk("R7 free 5 sets", 32'(s[16]), 32'd1);
    chk("R11 tx gated", 32'(tx_req), 32'd0);
    wr(A_CTRL, 32'h8);
    chk("R11 tx request", 32'(tx_req), 32'd1);
  endtask

  task automatic t_rx_threshold();
    logic [31:0] s;
    clean();
    wr(A_THR, 32'h2);
    epush(16'h1); epush(16'h2);
    wr(A_FSTAT, 32'h0);
    idle(1);
    rd(A_FSTAT, s); chk("R8 count 2 below", 32'(s[0]), 32'd0);
    epush(16'h3);
    idle(1);
    rd(A_FSTAT, s); chk("R8 count 3 sets", 32'(s[0]), 32'd1);
    chk("R11 rx gated", 32'(rx_req), 32'd0);
    wr(A_CTRL, 32'h4);
    chk("R11 rx request", 32'(rx_req), 32'd1);
    wr(A_FSTAT, 32'h1);
    chk("R9 write one keeps", 32'(echo[0]), 32'd1);
    wr(A_FSTAT, 32'h0);
    chk("R9 write zero clears", 32'(echo[0]), 32'd0);
    idle(1);
    rd(A_FSTAT, s); chk("R9 reasserts", 32'(s[0]), 32'd1);
  endtask

  task automatic t_error_sticky();
    logic [31:0] s;
    clean();
    rd(A_RXD, s);
    wr(A_ISTAT, 32'hFFFF_FFFF);
    rd(A_ISTAT, s); chk("R9 error kept", 32'(s[27]), 32'd1);
    wr(A_ISTAT, 32'h0);
    rd(A_ISTAT, s); chk("R9 error cleared", 32'(s[27]), 32'd0);
  endtask

  task automatic t_fifo_reset();
    logic [31:0] s;
    clean();
    epush(16'h1); epush(16'h2);
    wr(A_CTRL, 32'h1);
    rd(A_FSTAT, s); chk("R10 rx held empty", 32'(s[13:8]), 32'd0);
    epush(16'h5);
    rd(A_FSTAT, s); chk("R10 rx push ignored", 32'(s[13:8]), 32'd0);
    rd(A_RXD, s); chk("R10 rx read zero", s, 32'd0);
    rd(A_ISTAT, s); chk("R10 no error", 32'(s[29:26]), 32'd0);
    wr(A_CTRL, 32'h2);
    wr(A_TXD, 32'h7);
    wr(A_CTRL, 32'h0);
    rd(A_FSTAT, s); chk("R10 tx write dropped", 32'(s[29:24]), 32'd0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] s;
    clean();
    wr(A_TXD, 32'h1); wr(A_TXD, 32'h2);
    epush(16'h3);
    rd(A_RXD, s); rd(A_RXD, s);
    wr(A_CTRL, 32'h0001_0000);
    idle(1);
    rd(A_FSTAT, s); chk("R12 fstat cleared", s, 32'h0);
    rd(A_ISTAT, s); chk("R12 istat cleared", s, 32'h0200_0000);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_irq();
    logic [SW-1:0] w;
    clean();
    wr(A_CTRL, 32'h10);
    epop(w);
    chk("R14 other enable", 32'(err_irq), 32'd0);
    wr(A_CTRL, 32'h80);
    chk("R14 irq on", 32'(err_irq), 32'd1);
    wr(A_ISTAT, 32'h0);
    chk("R14 irq off", 32'(err_irq), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    tx_pop = 1'b0; rx_push = 1'b0; rx_word = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_order();
    t_full_overflow();
    t_tx_underflow();
    t_rx_underflow();
    t_rx_overflow();
    t_tx_threshold();
    t_rx_threshold();
    t_error_sticky();
    t_fifo_reset();
    t_soft_reset();
    t_irq();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule